// File: doc/BRIEF.md
# Online CRC Fault Test Module

This block watches the flits that leave each of the four output directions of a mesh router. Every flit carries an 8-bit check value, and the block recomputes that value from the 32-bit payload to find corruption while normal traffic is flowing. A mismatch is reported back to the neighbour that sent the flit over a one-bit line per direction. The block also takes single-cycle fault indications from the input buffers, the crossbar and the header check of each direction. It keeps a separate error count for each of the sixteen locations (four directions times four component classes).

A location that fails only occasionally is treated as having a transient fault. When a location fails the threshold number of times without enough clean traffic in between, it is classified as permanently faulty. The block then switches off the whole output port to save dynamic power and keeps the upstream line asserted for that direction. It also issues a one-cycle write command to an external fault register, naming the class of component that caused the escalation. A permanent classification is cleared only by reset.

Top module: `fault_test_unit`

## Requirements
- R1: After reset, port_en is 4'b1111, upstream_fault is 4'b0000 and fr_flag is 4'b0000.
- R2: The check value is CRC-8 with polynomial x^8+x^2+x+1 and an all-zero initial value, taken over the 32-bit payload MSB first. A valid flit on direction d whose flit_crc differs from this value sets upstream_fault[d] in the cycle after it is presented. A flit whose check value matches leaves upstream_fault[d] at 0.
- R3: A direction with no valid flit and no permanent fault shows upstream_fault 0 in the next cycle.
- R4: Fewer than ERR_LIMIT (default 3) errors at a location leave its port enabled.
- R5: The ERR_LIMIT-th error at one location clears port_en[d] in the cycle after that error. The port stays disabled until reset.
- R6: When a port is disabled, fr_flag[d] pulses for exactly one cycle, in the same cycle port_en[d] falls. fr_cause[2d+1:2d] gives the class, encoded link=0, buffer=1, crossbar=2, header=3. Further errors on that direction produce no more pulses.
- R7: While port_en[d] is 0, upstream_fault[d] is held at 1.
- R8: Each class keeps its own count. Errors spread over different classes of one direction do not add up.
- R9: CLEAN_RUN (default 256) consecutive error-free flits at a location clear its error count. A run that is one flit shorter does not clear it.
- R10: The four directions are independent. Errors on one direction do not change port_en or fr_flag of another.
- R11: When several classes of one direction escalate in the same cycle, fr_cause reports the lowest class code.
- R12: Buffer, crossbar and header fault inputs count as errors even in cycles with no valid flit on that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 4 | Flit present per direction (0=N,1=E,2=S,3=W) |
| flit_data | input | 128 | 32-bit payload per direction, direction d at [32d+31:32d] |
| flit_crc | input | 32 | Received check value per direction, at [8d+7:8d] |
| buf_fault | input | 4 | Input-buffer fault pulse per direction |
| xbar_fault | input | 4 | Crossbar fault pulse per direction |
| hdr_fault | input | 4 | Header check fault pulse per direction |
| upstream_fault | output | 4 | 1 = faulty flit or permanent fault, per direction |
| port_en | output | 4 | Output port enable, 0 once permanently faulty |
| fr_flag | output | 4 | One-cycle fault-register write per direction |
| fr_cause | output | 8 | Class of the escalating location, 2 bits per direction |

## Verification
The assertions check on every cycle that a disabled port never comes back, that fr_flag pulses exactly when port_en falls, and that a disabled direction keeps its upstream line high. They also check that an idle direction reports upstream only when it is disabled. Only the bench scenarios can show the arithmetic of the behaviour: the CRC value itself, the exact error count that triggers escalation, the separate counts per class, the clean run that clears a count (and the run one flit short that does not), the cause encoding and the priority between classes.

// File: rtl/fault_test_unit.sv
module fault_test_unit #(
  parameter int DIRS      = 4,
  parameter int FLIT_W    = 32,
  parameter int CRC_W     = 8,
  parameter logic [7:0] POLY = 8'h07,
  parameter int ERR_LIMIT = 3,
  parameter int CLEAN_RUN = 256
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIRS-1:0]       flit_valid,
  input  logic [DIRS*FLIT_W-1:0] flit_data,
  input  logic [DIRS*CRC_W-1:0] flit_crc,
  input  logic [DIRS-1:0]       buf_fault,
  input  logic [DIRS-1:0]       xbar_fault,
  input  logic [DIRS-1:0]       hdr_fault,
  output logic [DIRS-1:0]       upstream_fault,
  output logic [DIRS-1:0]       port_en,
  output logic [DIRS-1:0]       fr_flag,
  output logic [DIRS*2-1:0]     fr_cause
);
  localparam int CLS = 4;
  localparam int CW  = $clog2(ERR_LIMIT + 1);
  localparam int RW  = $clog2(CLEAN_RUN);

  function automatic logic [CRC_W-1:0] crc_of(input logic [FLIT_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = FLIT_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    return c;
  endfunction

  logic [CW-1:0]   err_cnt   [DIRS][CLS];
  logic [RW-1:0]   clean_cnt [DIRS][CLS];
  logic [DIRS-1:0] dead, uf_q;
  logic [DIRS-1:0] bad_crc;
  logic [CLS-1:0]  hit  [DIRS];
  logic [CLS-1:0]  seen [DIRS];
  logic [CLS-1:0]  esc  [DIRS];

  always_comb begin
    for (int d = 0; d < DIRS; d++) begin
      bad_crc[d] = flit_valid[d] &&
                   (crc_of(flit_data[d*FLIT_W +: FLIT_W]) != flit_crc[d*CRC_W +: CRC_W]);
      hit[d]  = {hdr_fault[d], xbar_fault[d], buf_fault[d], bad_crc[d]};
      seen[d] = {CLS{flit_valid[d]}};
      for (int c = 0; c < CLS; c++)
        esc[d][c] = hit[d][c] && (err_cnt[d][c] >= CW'(ERR_LIMIT - 1)) && !dead[d];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead     <= '0;
      uf_q     <= '0;
      fr_flag  <= '0;
      fr_cause <= '0;
      for (int d = 0; d < DIRS; d++)
        for (int c = 0; c < CLS; c++) begin
          err_cnt[d][c]   <= '0;
          clean_cnt[d][c] <= '0;
        end
    end else begin
      uf_q <= bad_crc;
      for (int d = 0; d < DIRS; d++) begin
        fr_flag[d] <= |esc[d];
        if (|esc[d]) begin
          dead[d] <= 1'b1;
          for (int c = CLS - 1; c >= 0; c--)
            if (esc[d][c]) fr_cause[d*2 +: 2] <= 2'(c);
        end
        for (int c = 0; c < CLS; c++) begin
          if (hit[d][c]) begin
            clean_cnt[d][c] <= '0;
            if (err_cnt[d][c] != CW'(ERR_LIMIT)) err_cnt[d][c] <= err_cnt[d][c] + 1'b1;
          end else if (seen[d][c]) begin
            if (clean_cnt[d][c] == RW'(CLEAN_RUN - 1)) begin
              clean_cnt[d][c] <= '0;
              err_cnt[d][c]   <= '0;
            end else begin
              clean_cnt[d][c] <= clean_cnt[d][c] + 1'b1;
            end
          end
        end
      end
    end
  end

  assign port_en        = ~dead;
  assign upstream_fault = uf_q | dead;
endmodule

module fault_test_unit_chk #(parameter int DIRS = 4) (
  input logic            clk,
  input logic            rst_n,
  input logic [DIRS-1:0] flit_valid,
  input logic [DIRS-1:0] upstream_fault,
  input logic [DIRS-1:0] port_en,
  input logic [DIRS-1:0] fr_flag
);
  a_r5_port_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((port_en & ~$past(port_en)) == '0));

  a_r6_flag_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fr_flag == ($past(port_en) & ~port_en)));

  a_r7_dead_reports: assert property (@(posedge clk) disable iff (!rst_n)
    ((~port_en & ~upstream_fault) == '0));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_valid == '0) |=> (upstream_fault == ~port_en));
endmodule

bind fault_test_unit fault_test_unit_chk #(.DIRS(DIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid),
  .upstream_fault(upstream_fault), .port_en(port_en), .fr_flag(fr_flag));

// File: tb/fault_test_unit_bench.sv
`timescale 1ns/1ps
module fault_test_unit_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] fv, bf, xf, hf;
  logic [127:0] fd;
  logic [31:0] fc;
  logic [3:0] uf, pe, ff;
  logic [7:0] cause;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_test_unit u_fault_test_unit (
    .clk(clk), .rst_n(rst_n), .flit_valid(fv), .flit_data(fd), .flit_crc(fc),
    .buf_fault(bf), .xbar_fault(xf), .hdr_fault(hf),
    .upstream_fault(uf), .port_en(pe), .fr_flag(ff), .fr_cause(cause));

  function automatic logic [7:0] ref_crc(input logic [31:0] p);
    logic [39:0] r = {p, 8'h00};
    for (int b = 39; b >= 8; b--)
      if (r[b]) r[b -: 9] = r[b -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic idle();
    fv = 0; bf = 0; xf = 0; hf = 0; fd = 0; fc = 0;
  endtask

  task automatic send(input int d, input logic [31:0] p, input bit bad);
    idle();
    fv[d] = 1'b1;
    fd[32*d +: 32] = p;
    fc[8*d +: 8] = ref_crc(p) ^ (bad ? 8'h01 : 8'h00);
  endtask

  task automatic do_reset();
    rst_n = 0; idle(); step(); step(); rst_n = 1;
  endtask

  task automatic link_err(input int d, input int n);
    for (int i = 0; i < n; i++) begin send(d, 32'h1234_5678 + i, 1); step(); end
  endtask

  task automatic clean(input int d, input int n);
    for (int i = 0; i < n; i++) begin send(d, 32'hA5A5_0000 ^ i, 0); step(); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    step();
    check("R1 port_en", pe, 4'hF);
    check("R1 upstream_fault", uf, 4'h0);
    check("R1 fr_flag", ff, 4'h0);

    for (int i = 0; i < 64; i++) begin
      logic [31:0] p = 32'h9E37_79B9 * i ^ (i << 13);
      idle(); fv = 4'hF;
      for (int d = 0; d < 4; d++) begin
        fd[32*d +: 32] = p + d;
        fc[8*d +: 8] = ref_crc(p + d);
      end
      step();
      check("R2 good crc sweep", uf, 4'h0);
    end
    idle(); step();
    check("R3 idle quiet", uf, 4'h0);
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 2; k++) begin
        send(d, 32'hC0DE_0000 + 32'(d * 16 + k), 1); step();
        check("R2 bad crc flagged", uf, 32'(1 << d));
        idle(); step();
        check("R3 idle after bad", uf, 4'h0);
      end
    check("R4 two errors no disable", pe, 4'hF);
    check("R10 no flag yet", ff, 4'h0);

    do_reset();
    link_err(2, 2);
    check("R4 below limit", pe, 4'hF);
    link_err(2, 1);
    check("R5 disabled after third", pe, 4'b1011);
    check("R6 flag pulse", ff, 4'b0100);
    check("R6 cause link", cause[5:4], 2'd0);
    check("R10 other dirs", pe & 4'b1011, 4'b1011);
    idle(); step();
    check("R6 pulse ends", ff, 4'h0);
    check("R7 held upstream", uf, 4'b0100);
    link_err(2, 3);
    check("R6 no repeat flag", ff, 4'h0);
    clean(2, 300);
    check("R5 sticky", pe, 4'b1011);
    check("R7 still held", uf, 4'b0100);

    do_reset();
    link_err(1, 2);
    for (int k = 0; k < 2; k++) begin
      send(1, 32'h55, 0); bf[1] = 1; step();
      send(1, 32'h66, 0); xf[1] = 1; step();
      idle(); hf[1] = 1; step();
    end
    check("R8 classes separate", pe, 4'hF);
    check("R12 no flag yet", ff, 4'h0);
    idle(); hf[1] = 1; step();
    check("R12 header w/o flit escalates", pe, 4'b1101);
    check("R6 cause header", cause[3:2], 2'd3);

    do_reset();
    link_err(0, 2); clean(0, 256); link_err(0, 2);
    check("R9 full clean run clears", pe, 4'hF);
    do_reset();
    link_err(0, 2); clean(0, 255); link_err(0, 1);
    check("R9 short run keeps count", pe, 4'b1110);

    do_reset();
    for (int k = 0; k < 2; k++) begin idle(); bf[3] = 1; step(); idle(); xf[3] = 1; step(); end
    check("R11 pre", pe, 4'hF);
    idle(); bf[3] = 1; xf[3] = 1; hf[3] = 1; step();
    check("R11 disabled", pe, 4'b0111);
    check("R11 lowest cause", cause[7:6], 2'd1);

    do_reset();
    send(0, 32'h1, 1); fv = 4'hF;
    for (int d = 1; d < 4; d++) begin fd[32*d +: 32] = 32'h77; fc[8*d +: 8] = ref_crc(32'h77); end
    step();
    check("R10 only dir0 flagged", uf, 4'b0001);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule